// File: doc/BRIEF.md
# Single-Cycle Six-Instruction Processor

This block is a 32-bit processor core that fetches, decodes, executes and retires one instruction on every rising clock edge. Its instruction set is a fixed set of six operations: unsigned add and subtract between registers, a bitwise OR with a 16-bit immediate, a word load, a word store and a branch taken when two registers hold equal values. Instruction and data storage are local word arrays inside the core. Reads from both arrays are combinational, and a store writes on the clock edge. The testbench fills the arrays before it releases reset.

On each cycle a combinational decoder turns the opcode and function fields into the datapath controls. These controls choose the destination register field, the second ALU operand, the extension mode of the immediate, the ALU operation, the write-back source, the write strobes and the next-address choice. The retiring instruction's register write, memory write and program counter are driven onto output ports, so a bench can follow execution cycle by cycle. A write shows on these ports while it is pending, before the edge that commits it.

Top module: `sc_cpu`

## Requirements
- R1: While `rst` is high, `pc_o` is 0, `rf_we_o` and `dm_we_o` are 0, and all 32 registers are cleared. After reset the first instruction is fetched from word 0.
- R2: The instruction fields are opcode [31:26], rs [25:21], rt [20:16], rd [15:11] and imm16 [15:0]. Opcode 0x00 with funct [5:0] = 0x21 writes R[rs]+R[rt] into R[rd], and funct 0x23 writes R[rs]-R[rt] into R[rd]. Both wrap modulo 2^32.
- R3: Opcode 0x0D writes R[rs] OR the zero-extended imm16 into R[rt].
- R4: Opcode 0x23 writes the data word at byte address R[rs] + sign-extended imm16 into R[rt]. The word index is taken from address bits [k+1:2].
- R5: Opcode 0x2B writes R[rt] to the data word at R[rs] + sign-extended imm16. It writes no register. A later load from that address returns the stored value.
- R6: Opcode 0x04 sets the next PC to PC+4+(sign-extended imm16 << 2) when R[rs]==R[rt], and to PC+4 otherwise. It writes neither register nor memory.
- R7: Register 0 always reads as zero. A write aimed at it leaves it zero.
- R8: Any other opcode, and opcode 0x00 with any other funct, writes no register and no memory, and the PC advances by 4.
- R9: Every instruction except a taken branch advances the PC by exactly 4 in one cycle. All state updates on the same rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pc_o | output | 32 | Address of the instruction executing this cycle |
| instr_o | output | 32 | Instruction word executing this cycle |
| rf_we_o | output | 1 | Register write pending at the next edge |
| rf_waddr_o | output | 5 | Destination register of the pending write |
| rf_wdata_o | output | 32 | Value of the pending register write |
| dm_we_o | output | 1 | Data-memory write pending at the next edge |
| dm_addr_o | output | 32 | Byte address computed by the ALU |
| dm_wdata_o | output | 32 | Store data (R[rt]) |

## Verification
The hardest situation to reach from the ports is a backward branch whose negative offset wraps the PC to word 0. It only happens when the branch sits deep in a program and its sign-extended immediate cancels the PC exactly. The bench reaches it by placing a beq r0,r0 with offset -7 at address 24, after a taken forward branch has skipped two words and an untaken one has fallen through. A second case needs the data path to carry a value all the way around. A store followed by a load from the same computed address, with a base register built by ori and a negative displacement for the first load, checks that the store committed and that sign extension reaches the address adder.

// File: rtl/sc_pkg.sv
package sc_pkg;

  localparam int unsigned XLEN = 32;

  localparam logic [5:0] OPC_RTYPE = 6'h00;
  localparam logic [5:0] OPC_ORI   = 6'h0D;
  localparam logic [5:0] OPC_LOAD  = 6'h23;
  localparam logic [5:0] OPC_STORE = 6'h2B;
  localparam logic [5:0] OPC_BEQ   = 6'h04;
  localparam logic [5:0] FN_ADDU   = 6'h21;
  localparam logic [5:0] FN_SUBU   = 6'h23;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_OR  = 2'd2
  } alu_op_e;

  typedef struct packed {
    logic    dst_rd;     // destination taken from rd (else rt)
    logic    use_imm;    // second ALU operand is the extended immediate
    logic    sext;       // sign-extend immediate (else zero-extend)
    alu_op_e alu_op;
    logic    mem_we;
    logic    reg_we;
    logic    wb_mem;     // write-back from data memory (else ALU)
    logic    is_branch;
  } ctrl_t;

  function automatic logic [XLEN-1:0] f_extend(input logic [15:0] imm, input logic sext);
    f_extend = sext ? {{(XLEN-16){imm[15]}}, imm} : {{(XLEN-16){1'b0}}, imm};
  endfunction

  function automatic logic [XLEN-1:0] f_alu(input alu_op_e op,
                                            input logic [XLEN-1:0] a,
                                            input logic [XLEN-1:0] b);
    case (op)
      ALU_SUB: f_alu = a - b;
      ALU_OR:  f_alu = a | b;
      default: f_alu = a + b;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] f_branch_target(input logic [XLEN-1:0] seq_pc,
                                                      input logic [XLEN-1:0] ext_imm);
    f_branch_target = seq_pc + {ext_imm[XLEN-3:0], 2'b00};
  endfunction

endpackage

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int unsigned NREGS = 32,
  parameter int unsigned DW    = 32,
  localparam int unsigned AW   = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ra_i,
  input  logic [AW-1:0] rb_i,
  output logic [DW-1:0] rda_o,
  output logic [DW-1:0] rdb_o,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [DW-1:0] wd_i
);

  logic [DW-1:0] regs [NREGS];
  logic          wr_live;

  assign wr_live = we_i && (wa_i != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (wr_live) begin
      regs[wa_i] <= wd_i;
    end
  end

  assign rda_o = regs[ra_i];
  assign rdb_o = regs[rb_i];

  // R7: register 0 is never written, so both read ports return zero for it
  a_r7_zero_port_a: assert property (@(posedge clk) disable iff (rst)
    (ra_i == '0) |-> (rda_o == '0));
  a_r7_zero_port_b: assert property (@(posedge clk) disable iff (rst)
    (rb_i == '0) |-> (rdb_o == '0));

endmodule

// File: rtl/sc_decoder.sv
module sc_decoder
  import sc_pkg::*;
(
  input  logic [5:0] opcode_i,
  input  logic [5:0] funct_i,
  output ctrl_t      ctrl_o,
  output logic       illegal_o
);

  always_comb begin
    ctrl_o    = '{dst_rd: 1'b0, use_imm: 1'b0, sext: 1'b0, alu_op: ALU_ADD,
                  mem_we: 1'b0, reg_we: 1'b0, wb_mem: 1'b0, is_branch: 1'b0};
    illegal_o = 1'b0;
    case (opcode_i)
      OPC_RTYPE: begin
        ctrl_o.dst_rd = 1'b1;
        case (funct_i)
          FN_ADDU: begin ctrl_o.reg_we = 1'b1; ctrl_o.alu_op = ALU_ADD; end
          FN_SUBU: begin ctrl_o.reg_we = 1'b1; ctrl_o.alu_op = ALU_SUB; end
          default: illegal_o = 1'b1;
        endcase
      end
      OPC_ORI: begin
        ctrl_o.use_imm = 1'b1;
        ctrl_o.alu_op  = ALU_OR;
        ctrl_o.reg_we  = 1'b1;
      end
      OPC_LOAD: begin
        ctrl_o.use_imm = 1'b1;
        ctrl_o.sext    = 1'b1;
        ctrl_o.reg_we  = 1'b1;
        ctrl_o.wb_mem  = 1'b1;
      end
      OPC_STORE: begin
        ctrl_o.use_imm = 1'b1;
        ctrl_o.sext    = 1'b1;
        ctrl_o.mem_we  = 1'b1;
      end
      OPC_BEQ: begin
        ctrl_o.sext      = 1'b1;
        ctrl_o.alu_op    = ALU_SUB;
        ctrl_o.is_branch = 1'b1;
      end
      default: illegal_o = 1'b1;
    endcase
  end

endmodule

// File: rtl/sc_pc_unit.sv
module sc_pc_unit
  import sc_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            take_i,
  input  logic [XLEN-1:0] ext_imm_i,
  output logic [XLEN-1:0] pc_o
);

  logic [XLEN-1:0] pc_q;
  logic [XLEN-1:0] seq_pc;
  logic [XLEN-1:0] pc_next;

  assign seq_pc  = pc_q + XLEN'(4);
  assign pc_next = take_i ? f_branch_target(seq_pc, ext_imm_i) : seq_pc;

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_next;
  end

  assign pc_o = pc_q;

  // R9: without a taken branch the PC moves by one word
  a_r9_seq_step: assert property (@(posedge clk) disable iff (rst)
    !take_i |=> (pc_q == $past(pc_q) + 32'd4));

  // R6: a taken branch lands on PC+4 plus the word offset
  a_r6_branch_target: assert property (@(posedge clk) disable iff (rst)
    take_i |=> (pc_q == $past(pc_q) + 32'd4 + {$past(ext_imm_i[XLEN-3:0]), 2'b00}));

endmodule

// File: rtl/sc_cpu.sv
module sc_cpu
  import sc_pkg::*;
#(
  parameter int unsigned IMEM_WORDS = 64,
  parameter int unsigned DMEM_WORDS = 64
) (
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] pc_o,
  output logic [31:0] instr_o,
  output logic        rf_we_o,
  output logic [4:0]  rf_waddr_o,
  output logic [31:0] rf_wdata_o,
  output logic        dm_we_o,
  output logic [31:0] dm_addr_o,
  output logic [31:0] dm_wdata_o
);

  localparam int unsigned IA_W = $clog2(IMEM_WORDS);
  localparam int unsigned DA_W = $clog2(DMEM_WORDS);

  logic [XLEN-1:0] imem [IMEM_WORDS];
  logic [XLEN-1:0] dmem [DMEM_WORDS];

  logic [XLEN-1:0] pc;
  logic [XLEN-1:0] instr;
  logic [4:0]      f_rs, f_rt, f_rd;
  logic [15:0]     f_imm;
  ctrl_t           ctrl;
  logic            illegal;
  logic [XLEN-1:0] rs_val, rt_val, ext_imm, alu_b, alu_y, mem_rdata, wb_data;
  logic [4:0]      wr_addr;
  logic            alu_zero, br_taken, reg_commit, mem_commit;

  assign instr = imem[pc[IA_W+1:2]];
  assign f_rs  = instr[25:21];
  assign f_rt  = instr[20:16];
  assign f_rd  = instr[15:11];
  assign f_imm = instr[15:0];

  sc_decoder u_dec (
    .opcode_i  (instr[31:26]),
    .funct_i   (instr[5:0]),
    .ctrl_o    (ctrl),
    .illegal_o (illegal)
  );

  sc_regfile #(.NREGS(32), .DW(XLEN)) u_rf (
    .clk   (clk),
    .rst   (rst),
    .ra_i  (f_rs),
    .rb_i  (f_rt),
    .rda_o (rs_val),
    .rdb_o (rt_val),
    .we_i  (reg_commit),
    .wa_i  (wr_addr),
    .wd_i  (wb_data)
  );

  assign ext_imm   = f_extend(f_imm, ctrl.sext);
  assign alu_b     = ctrl.use_imm ? ext_imm : rt_val;
  assign alu_y     = f_alu(ctrl.alu_op, rs_val, alu_b);
  assign alu_zero  = (alu_y == '0);
  assign br_taken  = ctrl.is_branch && alu_zero;

  assign mem_rdata = dmem[alu_y[DA_W+1:2]];
  assign wb_data   = ctrl.wb_mem ? mem_rdata : alu_y;
  assign wr_addr   = ctrl.dst_rd ? f_rd : f_rt;

  assign reg_commit = ctrl.reg_we && !rst;
  assign mem_commit = ctrl.mem_we && !rst;

  always_ff @(posedge clk) begin
    if (mem_commit) dmem[alu_y[DA_W+1:2]] <= rt_val;
  end

  sc_pc_unit u_pc (
    .clk       (clk),
    .rst       (rst),
    .take_i    (br_taken),
    .ext_imm_i (ext_imm),
    .pc_o      (pc)
  );

  assign pc_o       = pc;
  assign instr_o    = instr;
  assign rf_we_o    = reg_commit;
  assign rf_waddr_o = wr_addr;
  assign rf_wdata_o = wb_data;
  assign dm_we_o    = mem_commit;
  assign dm_addr_o  = alu_y;
  assign dm_wdata_o = rt_val;

  // R8: an unrecognised encoding must not touch any state but the PC
  a_r8_illegal_quiet: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (!rf_we_o && !dm_we_o));

  // R5/R6: a store or a branch never writes a register; one write kind per cycle
  a_r5_single_write: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rf_we_o, dm_we_o}));

  // R1: during reset nothing is committed and the PC is held at zero
  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (pc_o == 32'd0));

endmodule

// File: tb/test_sc_cpu.sv
`timescale 1ns/1ps
module test_sc_cpu;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pc_o, instr_o, rf_wdata_o, dm_addr_o, dm_wdata_o;
  logic        rf_we_o, dm_we_o;
  logic [4:0]  rf_waddr_o;
  int          checks = 0;
  int          errors = 0;

  always #5 clk = ~clk;

  sc_cpu i_sc_cpu (
    .clk(clk), .rst(rst), .pc_o(pc_o), .instr_o(instr_o),
    .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o),
    .dm_we_o(dm_we_o), .dm_addr_o(dm_addr_o), .dm_wdata_o(dm_wdata_o)
  );

  function automatic logic [31:0] enc_r(input logic [5:0] fn, input int rs, input int rt, input int rd);
    enc_r = {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
    enc_i = {op, 5'(rs), 5'(rt), imm};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic chk_wr(input string req, input int rd, input logic [31:0] val);
    chk({req, " reg write enable"}, 32'(rf_we_o), 32'd1);
    chk({req, " reg write addr"}, 32'(rf_waddr_o), 32'(rd));
    chk({req, " reg write data"}, rf_wdata_o, val);
  endtask

  task automatic clear_imem();
    for (int i = 0; i < 64; i++) i_sc_cpu.imem[i] = 32'h0000_0000;
  endtask

  task automatic run_from_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    #1;
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    chk("R1 pc in reset", pc_o, 32'd0);
    chk("R1 no reg write in reset", 32'(rf_we_o), 32'd0);
    chk("R1 no mem write in reset", 32'(dm_we_o), 32'd0);
  endtask

  task automatic t_arith();
    clear_imem();
    i_sc_cpu.imem[0] = enc_i(6'h0D, 0, 1, 16'h1234);
    i_sc_cpu.imem[1] = enc_i(6'h0D, 0, 2, 16'hFFFF);
    i_sc_cpu.imem[2] = enc_r(6'h21, 1, 2, 3);
    i_sc_cpu.imem[3] = enc_r(6'h23, 1, 2, 4);
    i_sc_cpu.imem[4] = enc_r(6'h23, 0, 2, 5);
    i_sc_cpu.imem[5] = enc_r(6'h21, 5, 5, 6);
    run_from_reset();
    chk("R1 first fetch at 0", pc_o, 32'd0);
    chk_wr("R3 ori", 1, 32'h0000_1234);                  step();
    chk_wr("R3 ori zero-extend", 2, 32'h0000_FFFF);      step();
    chk_wr("R2 addu", 3, 32'h0001_1233);                 step();
    chk_wr("R2 subu negative", 4, 32'hFFFF_1235);        step();
    chk_wr("R2 subu from zero", 5, 32'hFFFF_0001);       step();
    chk_wr("R2 addu wraps", 6, 32'hFFFE_0002);
    chk("R9 pc after five steps", pc_o, 32'd20);
  endtask

  task automatic t_memory();
    clear_imem();
    i_sc_cpu.dmem[7] = 32'hCAFE_F00D;
    i_sc_cpu.imem[0] = enc_i(6'h0D, 0, 1, 16'h0020);
    i_sc_cpu.imem[1] = enc_i(6'h23, 1, 2, 16'hFFFC);
    i_sc_cpu.imem[2] = enc_i(6'h2B, 1, 2, 16'h0008);
    i_sc_cpu.imem[3] = enc_i(6'h23, 1, 3, 16'h0008);
    run_from_reset();
    step();
    chk_wr("R4 load negative offset", 2, 32'hCAFE_F00D); step();
    chk("R5 store enable", 32'(dm_we_o), 32'd1);
    chk("R5 store address", dm_addr_o, 32'h0000_0028);
    chk("R5 store data", dm_wdata_o, 32'hCAFE_F00D);
    chk("R5 store writes no register", 32'(rf_we_o), 32'd0);
    step();
    chk_wr("R5 load back stored word", 3, 32'hCAFE_F00D);
  endtask

  task automatic t_branch();
    clear_imem();
    i_sc_cpu.imem[0] = enc_i(6'h0D, 0, 1, 16'h0005);
    i_sc_cpu.imem[1] = enc_i(6'h0D, 0, 2, 16'h0005);
    i_sc_cpu.imem[2] = enc_i(6'h04, 1, 2, 16'h0002);
    i_sc_cpu.imem[3] = enc_i(6'h0D, 0, 3, 16'h00AA);
    i_sc_cpu.imem[4] = enc_i(6'h0D, 0, 3, 16'h00BB);
    i_sc_cpu.imem[5] = enc_i(6'h04, 1, 0, 16'h0005);
    i_sc_cpu.imem[6] = enc_i(6'h04, 0, 0, 16'hFFF9);
    run_from_reset();
    step(); step();
    chk("R6 branch writes no register", 32'(rf_we_o), 32'd0);
    chk("R6 branch writes no memory", 32'(dm_we_o), 32'd0);
    step();
    chk("R6 taken forward", pc_o, 32'd20);
    step();
    chk("R6 not taken falls through", pc_o, 32'd24);
    step();
    chk("R6 taken backward to 0", pc_o, 32'd0);
    chk_wr("R6 re-executes first word", 1, 32'h0000_0005);
  endtask

  task automatic t_zero_reg();
    clear_imem();
    i_sc_cpu.imem[0] = enc_i(6'h0D, 0, 0, 16'h0055);
    i_sc_cpu.imem[1] = enc_r(6'h21, 0, 0, 1);
    run_from_reset();
    step();
    chk_wr("R7 reg0 reads zero after write", 1, 32'h0000_0000);
  endtask

  task automatic t_illegal();
    clear_imem();
    i_sc_cpu.imem[0] = enc_i(6'h0D, 0, 1, 16'h0007);
    i_sc_cpu.imem[1] = enc_i(6'h3F, 1, 1, 16'h1234);
    i_sc_cpu.imem[2] = enc_r(6'h20, 1, 1, 1);
    i_sc_cpu.imem[3] = enc_r(6'h21, 1, 0, 2);
    run_from_reset();
    step();
    chk("R8 bad opcode no reg write", 32'(rf_we_o), 32'd0);
    chk("R8 bad opcode no mem write", 32'(dm_we_o), 32'd0);
    step();
    chk("R8 bad opcode pc+4", pc_o, 32'd8);
    chk("R8 bad funct no reg write", 32'(rf_we_o), 32'd0);
    chk("R8 bad funct no mem write", 32'(dm_we_o), 32'd0);
    step();
    chk("R8 bad funct pc+4", pc_o, 32'd12);
    chk_wr("R8 r1 untouched by no-ops", 2, 32'h0000_0007);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_arith();
    t_memory();
    t_branch();
    t_zero_reg();
    t_illegal();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule